// File: doc/BRIEF.md
# Toggle-Stage Signature Compactor with Per-Net Gating

This block compacts the response bits of a set of nets under test into one signature, at one step per clock, during at-speed interconnect testing. Its storage stages are toggle flip-flops. The feedback is internal XOR, set by a characteristic polynomial that the integrator supplies. A response bit enters the register only when the matching bit of a gating mask is set, and the AND gate for that bit sits in front of the stage.

The mask sets the operating mode. With every mask bit set, all nets are folded in together as a multi-input register, and one golden comparison tells a good interconnect from a faulty one. With a single mask bit set, the register becomes a single-input register on that one net. The same test sequence is then replayed once per net, and the signature that net produces shows whether it is faulty and points to the kind of fault.

The mask is captured only by a clear, so a run always starts from zero with a fixed mode. A compare strobe checks the current signature against a golden value and sets a mismatch flag.

Top module: `tff_sig_compactor`

## Requirements
- R1: After reset the signature is all zero, the mismatch flag is 0, and the captured gating mask is all ones, which is parallel mode.
- R2: While `clear` is high at a clock edge, the signature becomes zero and the mismatch flag becomes 0 on that edge. The `gate_en` value present at that edge becomes the captured mask. `clear` takes priority over `cmp_en`.
- R3: On each edge with `cmp_en` high and `clear` low, every stage i computes its toggle input as t_i = q[i-1] ^ (m_i & resp_i) ^ (c_i & q[W-1]) and then takes q_i ^ t_i. Here m is the captured mask, c is the `TAPS` parameter with bit 0 always treated as 1, and q[-1] is 0.
- R4: On an edge with `cmp_en` low and `clear` low, the signature keeps its value.
- R5: With the captured mask all ones, every response bit takes part in the update of R3, so the block works as a multi-input register.
- R6: With exactly one mask bit k set, the signature depends only on `resp[k]`. Changes on the other response bits have no effect on it.
- R7: Changing `gate_en` while `clear` is low has no effect. The mask captured at the last clear stays in force until the next clear.
- R8: Starting from zero, a run in which every gated response bit is 0 leaves the signature at zero, as a net stuck at 0 does.
- R9: On an edge with `compare` high and `clear` low, the mismatch flag is set to (signature != `golden`), taken from the signature present before that edge. At other times the flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of signature and flag; also captures the mask |
| cmp_en | input | 1 | Compaction step enable |
| resp | input | WIDTH | Response bits from the nets under test |
| gate_en | input | WIDTH | Gating mask, captured on clear |
| golden | input | WIDTH | Expected signature |
| compare | input | 1 | Compare strobe |
| signature | output | WIDTH | Current register state |
| mismatch | output | 1 | Result of the last comparison |

## Verification
The case that is hardest to reach from the ports is a `gate_en` change in the middle of a run. Its only visible trace is a signature that still follows the mask captured earlier. The bench gets there by capturing a single-net mask, compacting part of a sequence, and then driving a different mask without a clear. It then drives bits of non-selected nets with values opposite to those used in its reference model, so any leak shows up as a wrong signature. Stage state that is reachable only through feedback is covered by a sweep over every 8-bit response word applied from zero, each followed by a second step that brings the top stage's feedback into play.

// File: rtl/sigc_pkg.sv
package sigc_pkg;

   typedef enum logic [1:0] {
      GMODE_OFF    = 2'd0,
      GMODE_SINGLE = 2'd1,
      GMODE_PART   = 2'd2,
      GMODE_ALL    = 2'd3
   } gate_mode_e;

   // Classify a mask of up to 64 bits (only the low w bits count).
   function automatic gate_mode_e classify_mask(input logic [63:0] m, input int w);
      int ones;
      ones = 0;
      for (int i = 0; i < w; i++) ones += int'(m[i]);
      if (ones == 0)      return GMODE_OFF;
      else if (ones == 1) return GMODE_SINGLE;
      else if (ones == w) return GMODE_ALL;
      else                return GMODE_PART;
   endfunction

endpackage

// File: rtl/sigc_gate.sv
module sigc_gate #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [WIDTH-1:0] gate_en,
   input  logic [WIDTH-1:0] resp,
   output logic [WIDTH-1:0] gated
);
   import sigc_pkg::*;

   logic [WIDTH-1:0] mask_q;
   logic [63:0]      mask_wide;
   gate_mode_e       mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mask_q <= '1;
      else if (clear) mask_q <= gate_en;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_and
      assign gated[i] = mask_q[i] & resp[i];
   end

   always_comb begin
      mask_wide = '0;
      mask_wide[WIDTH-1:0] = mask_q;
      mode = classify_mask(mask_wide, WIDTH);
   end

   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> $stable(mask_q));
   // R7
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> $stable(mode));
   // R6
   single_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == GMODE_SINGLE) |-> ($countones(gated) <= 1));
endmodule

// File: rtl/sigc_tstage.sv
module sigc_tstage (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic t,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (clr)      q <= 1'b0;
      else if (en && t)  q <= ~q;
   end

   // R4
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(en && t)) |=> $stable(q));
endmodule

// File: rtl/sigc_core.sv
module sigc_core #(
   parameter int               WIDTH = 32,
   parameter logic [WIDTH-1:0] TAPS  = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [WIDTH-1:0] gated,
   output logic [WIDTH-1:0] state
);
   localparam logic [WIDTH-1:0] CTAP = TAPS | {{(WIDTH-1){1'b0}}, 1'b1};
   localparam int               MSB  = WIDTH - 1;

   logic [WIDTH-1:0] tog;
   logic             top;

   assign top = state[MSB];

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_first
         assign tog[i] = gated[i] ^ top;
      end else if (CTAP[i]) begin : g_tap
         assign tog[i] = state[i-1] ^ gated[i] ^ top;
      end else begin : g_plain
         assign tog[i] = state[i-1] ^ gated[i];
      end
      sigc_tstage u_st (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clear),
         .en    (step),
         .t     (tog[i]),
         .q     (state[i])
      );
   end

   // R2
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (state == '0));
   // R8
   zero_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && step && state == '0 && gated == '0) |=> (state == '0));
   // R3
   first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && step && state == '0) |=> (state == $past(gated)));
endmodule

// File: rtl/sigc_cmp.sv
module sigc_cmp #(
   parameter int WIDTH   = 32,
   parameter bit CMP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             compare,
   input  logic [WIDTH-1:0] sig,
   input  logic [WIDTH-1:0] golden,
   output logic             flag
);
   logic diff;
   assign diff = |(sig ^ golden);

   if (CMP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flag <= 1'b0;
         else if (clear)   flag <= 1'b0;
         else if (compare) flag <= diff;
      end
      // R9
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clear && !compare) |=> $stable(flag));
      // R9
      flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!clear && compare && sig == golden) |=> !flag);
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n ^ clear;
      assign flag = compare & diff;
   end
endmodule

// File: rtl/tff_sig_compactor.sv
module tff_sig_compactor #(
   parameter int               WIDTH   = 32,
   parameter logic [WIDTH-1:0] TAPS    = 32'h0040_0007,
   parameter bit               CMP_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             cmp_en,
   input  logic [WIDTH-1:0] resp,
   input  logic [WIDTH-1:0] gate_en,
   input  logic [WIDTH-1:0] golden,
   input  logic             compare,
   output logic [WIDTH-1:0] signature,
   output logic             mismatch
);
   if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
      $error("tff_sig_compactor: WIDTH must lie in 2..64");
   end
   if (TAPS[0] !== 1'b1) begin : g_bad_taps
      $error("tff_sig_compactor: TAPS bit 0 must be 1");
   end

   logic [WIDTH-1:0] gated;

   sigc_gate #(.WIDTH(WIDTH)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .gate_en (gate_en),
      .resp    (resp),
      .gated   (gated)
   );

   sigc_core #(.WIDTH(WIDTH), .TAPS(TAPS)) u_core (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .step  (cmp_en),
      .gated (gated),
      .state (signature)
   );

   sigc_cmp #(.WIDTH(WIDTH), .CMP_REG(CMP_REG)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (clear),
      .compare (compare),
      .sig     (signature),
      .golden  (golden),
      .flag    (mismatch)
   );

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !cmp_en) |=> $stable(signature));
   // R2
   clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && CMP_REG) |=> !mismatch);
endmodule

// File: tb/sim_tff_sig_compactor.sv
module sim_tff_sig_compactor;
   localparam int         W    = 8;
   localparam logic [7:0] TAPS = 8'h1D;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         clear = 1'b0, cmp_en = 1'b0, compare = 1'b0;
   logic [W-1:0] resp = '0, gate_en = '1, golden = '0;
   logic [W-1:0] signature;
   logic         mismatch;
   int           checks = 0, errors = 0;
   logic [W-1:0] mdl_mask, mdl_q;

   always #4 clk = ~clk;

   tff_sig_compactor #(.WIDTH(W), .TAPS(TAPS), .CMP_REG(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .clear(clear), .cmp_en(cmp_en),
      .resp(resp), .gate_en(gate_en), .golden(golden), .compare(compare),
      .signature(signature), .mismatch(mismatch));

   function automatic logic [W-1:0] nxt(input logic [W-1:0] q, input logic [W-1:0] g);
      logic [W-1:0] r;
      logic [W-1:0] c;
      logic         fb;
      c = TAPS | 8'h01;
      for (int i = 0; i < W; i++) begin
         fb   = (i == 0) ? 1'b0 : q[i-1];
         r[i] = q[i] ^ (fb ^ g[i] ^ (c[i] & q[W-1]));
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_clear(input logic [W-1:0] m);
      @(negedge clk);
      clear = 1'b1; gate_en = m; cmp_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      clear = 1'b0;
      mdl_mask = m; mdl_q = '0;
   endtask

   task automatic do_step(input logic [W-1:0] v);
      @(negedge clk);
      cmp_en = 1'b1; resp = v;
      @(posedge clk);
      @(negedge clk);
      cmp_en = 1'b0;
      mdl_q = nxt(mdl_q, v & mdl_mask);
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] seq [0:15];
      logic [W-1:0] s;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 sig", signature, '0);
      chk("R1 flag", {7'b0, mismatch}, '0);
      rst_n = 1'b1;
      mdl_mask = '1; mdl_q = '0;
      do_step(8'hA5);
      chk("R1 mask all ones", signature, nxt('0, 8'hA5));

      // R3 R5 sweep of every response word from zero, plus a second step
      for (int v = 0; v < 256; v++) begin
         do_clear('1);
         do_step(v[7:0]);
         chk("R3 first step", signature, mdl_q);
         do_step({v[0], v[7:1]} ^ 8'h3C);
         chk("R5 parallel two steps", signature, mdl_q);
      end

      // R4 hold without cmp_en
      s = signature;
      @(negedge clk); resp = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R4 hold", signature, s);

      // R2 clear beats cmp_en
      @(negedge clk); clear = 1'b1; cmp_en = 1'b1; resp = 8'hFF; gate_en = '1;
      @(posedge clk); @(negedge clk);
      clear = 1'b0; cmp_en = 1'b0; mdl_q = '0; mdl_mask = '1;
      chk("R2 clear priority", signature, '0);

      for (int k = 0; k < 16; k++) seq[k] = 8'(k * 37 + 11) ^ 8'(k << 3);

      // R6 single-net mode per net; other nets driven with noise
      for (int n = 0; n < W; n++) begin
         logic [W-1:0] ref_q;
         do_clear(8'h01 << n);
         ref_q = '0;
         for (int k = 0; k < 16; k++) begin
            do_step(seq[k]);
            ref_q = nxt(ref_q, seq[k] & (8'h01 << n));
         end
         chk("R6 single net", signature, ref_q);
      end

      // R6 R7 mask change mid-run without clear, noise on other nets
      do_clear(8'h04);
      for (int k = 0; k < 8; k++) do_step(seq[k]);
      @(negedge clk); gate_en = 8'hFB;
      for (int k = 8; k < 16; k++) begin
         @(negedge clk);
         cmp_en = 1'b1; resp = seq[k] ^ 8'hFB;
         @(posedge clk); @(negedge clk);
         cmp_en = 1'b0;
         mdl_q = nxt(mdl_q, seq[k] & 8'h04);
      end
      chk("R7 mask change ignored", signature, mdl_q);

      // R8 stuck-at-0 net in single mode and parallel mode
      do_clear(8'h10);
      for (int k = 0; k < 10; k++) do_step(8'hEF);
      chk("R8 stuck0 single", signature, '0);
      do_clear('1);
      for (int k = 0; k < 10; k++) do_step(8'h00);
      chk("R8 stuck0 parallel", signature, '0);

      // R9 compare match and mismatch
      do_clear('1);
      for (int k = 0; k < 5; k++) do_step(seq[k]);
      @(negedge clk); compare = 1'b1; golden = mdl_q ^ 8'h01;
      @(posedge clk); @(negedge clk); compare = 1'b0;
      chk("R9 mismatch set", {7'b0, mismatch}, 8'h01);
      golden = mdl_q;
      repeat (2) @(negedge clk);
      chk("R9 flag held", {7'b0, mismatch}, 8'h01);
      @(negedge clk); compare = 1'b1;
      @(posedge clk); @(negedge clk); compare = 1'b0;
      chk("R9 match clears flag", {7'b0, mismatch}, 8'h00);
      // R9 compare during a step uses pre-step value
      @(negedge clk); compare = 1'b1; cmp_en = 1'b1; resp = 8'h5A; golden = mdl_q;
      @(posedge clk); @(negedge clk); compare = 1'b0; cmp_en = 1'b0;
      mdl_q = nxt(mdl_q, 8'h5A);
      chk("R9 pre-step compare", {7'b0, mismatch}, 8'h00);
      chk("R3 step with compare", signature, mdl_q);
      // R2 clear drops flag
      @(negedge clk); compare = 1'b1; golden = ~mdl_q;
      @(posedge clk); @(negedge clk); compare = 1'b0;
      do_clear('1);
      chk("R2 clear flag", {7'b0, mismatch}, 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule